// File: doc/BRIEF.md
# Accumulator ALU and Compare-Branch Unit

This block is the execute stage of a 16-bit accumulator machine. Each cycle in which `opValid` is high it takes an operation code, a first operand (the value of the register the instruction names), a second source (a second register value or an immediate, chosen by `useImm`), the current accumulator value and a jump target. One clock edge later it presents a register write request, an optional remainder write, an optional branch decision and an error strobe. The register file, fetch logic and memory sit around it and act on these outputs.

Where a result lands depends on the operation. Two-input arithmetic and logic, and bitwise inversion, go to the accumulator and leave the named register untouched. Increment, decrement, negation, shifts and the byte operations write back into the named register. Division writes a quotient to the accumulator and a remainder to a separate remainder register. Conditional jumps compare the signed second source against the accumulator and, when the condition holds, hand the jump target on to the instruction pointer.

All arithmetic is 16-bit two's complement. Division truncates toward zero. Division by zero is defined behaviour and not a trap.

Top module: `accBranchUnit`

## Requirements
- R1: ADD (opcode 1), SUB (2, first operand minus second source), AND (4), OR (5), XOR (6) and NOT (7, inverts the first operand) raise `wrEn` with `wrDest`=0, which selects the accumulator. The second source is `immValue` when `useImm`=1 and `operandB` when `useImm`=0.
- R2: MUL (opcode 3) writes the low 16 bits of the product of the first operand and the second source to the accumulator (`wrDest`=0).
- R3: INC (8), DEC (9) and NEG (10, two's complement negation) write their result with `wrDest`=1, which selects the named operand register. The values wrap modulo 2^16.
- R4: DIV (opcode 13) treats both inputs as signed. It writes the quotient, truncated toward zero, to the accumulator (`wrEn`=1, `wrDest`=0). It also raises `remWrEn` with the remainder, which takes the dividend's sign, on `remValue`.
- R5: When DIV has a zero divisor, the accumulator result is 0xFFFF and `remValue` carries the dividend. `remWrEn` and `divZeroErr` are both raised for that one cycle.
- R6: The byte operations raise `wrByte` and write to the operand register (`wrDest`=1), and the upper 8 result bits are zero. NEGB (opcode 14) negates the sign-extended low byte of the first operand. LDB (opcode 15) loads the low byte of the second source.
- R7: SHL (opcode 11) and SHR (opcode 12) shift the first operand by the unsigned 16-bit second source and write back with `wrDest`=1. SHR is arithmetic. A shift amount of 16 or more gives 0 for SHL and sixteen copies of the sign bit for SHR.
- R8: Each jump sets `branchTaken` with `branchTarget` equal to `jumpTarget` when its condition holds, and never raises `wrEn`. The conditions compare the signed second source S against the signed `accIn`: JNE (16) S≠ACC, JEQ (17) S=ACC, JGT (18) S>ACC, JLT (19) S<ACC, JGE (20) S≥ACC, JLE (21) S≤ACC. JMP (22) is always taken.
- R9: Results appear exactly one clock after the edge that samples `opValid`=1. Every strobe (`wrEn`, `wrByte`, `remWrEn`, `branchTaken`, `divZeroErr`) is low in the cycle after an edge with `opValid`=0, after NOP (opcode 0) and after an undefined opcode (23 to 31). All outputs are zero while `rstN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 5 | Operation code |
| useImm | input | 1 | Second source is `immValue` (1) or `operandB` (0) |
| operandA | input | 16 | Value of the named operand register |
| operandB | input | 16 | Value of the second register |
| immValue | input | 16 | Immediate value |
| accIn | input | 16 | Current accumulator value |
| jumpTarget | input | 16 | Target address for jumps |
| wrEn | output | 1 | Register write request |
| wrDest | output | 1 | 0: accumulator, 1: operand register |
| wrByte | output | 1 | Byte write, upper byte already cleared |
| resultValue | output | 16 | Value to write |
| remWrEn | output | 1 | Remainder register write request |
| remValue | output | 16 | Remainder value |
| branchTaken | output | 1 | Jump condition met |
| branchTarget | output | 16 | Address to load into the instruction pointer |
| divZeroErr | output | 1 | Division by zero was attempted |

## Verification
The only state in the block is its output register stage, so a wrong decode or a wrong stored value shows at the ports on the cycle right after the operation. Examples are a stuck destination select, a missing byte clear or a strobe that is not gated. A strobe that outlives its operation shows as a write or a branch in the following idle cycle, so each operation is followed by an idle cycle in which the bench expects every strobe low. Signed-versus-unsigned faults only appear with operands of mixed sign. The compare and divide vectors therefore cross the sign boundary on purpose.

// File: rtl/accUnitPkg.sv
package accUnitPkg;

  localparam int DATA_W = 16;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_SUB  = 5'd2,
    OP_MUL  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOT  = 5'd7,
    OP_INC  = 5'd8,
    OP_DEC  = 5'd9,
    OP_NEG  = 5'd10,
    OP_SHL  = 5'd11,
    OP_SHR  = 5'd12,
    OP_DIV  = 5'd13,
    OP_NEGB = 5'd14,
    OP_LDB  = 5'd15,
    OP_JNE  = 5'd16,
    OP_JEQ  = 5'd17,
    OP_JGT  = 5'd18,
    OP_JLT  = 5'd19,
    OP_JGE  = 5'd20,
    OP_JLE  = 5'd21,
    OP_JMP  = 5'd22
  } opCode_e;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_MUL, FN_AND, FN_OR, FN_XOR, FN_NOT,
    FN_INC, FN_DEC, FN_NEG, FN_NEGB, FN_SHL, FN_SHR, FN_DIV, FN_LDB
  } aluFn_e;

  typedef enum logic [2:0] {
    CMP_NE, CMP_EQ, CMP_GT, CMP_LT, CMP_GE, CMP_LE, CMP_ALWAYS
  } cmpSel_e;

  // Strobes from control to datapath; all zero when nothing executes.
  typedef struct packed {
    logic    regWr;
    logic    toOper;
    logic    byteWr;
    logic    remWr;
    logic    zeroChk;
    logic    isBranch;
    aluFn_e  fn;
    cmpSel_e cmp;
  } ctrl_t;

endpackage

// File: rtl/accUnitCtrl.sv
module accUnitCtrl
  import accUnitPkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output ctrl_t           ctrl
);

  opCode_e op;
  assign op = opCode_e'(opCode);

  always_comb begin
    ctrl = '0;
    ctrl.fn  = FN_ADD;
    ctrl.cmp = CMP_ALWAYS;
    if (opValid) begin
      case (op)
        OP_ADD:  begin ctrl.regWr = 1'b1; ctrl.fn = FN_ADD; end
        OP_SUB:  begin ctrl.regWr = 1'b1; ctrl.fn = FN_SUB; end
        OP_MUL:  begin ctrl.regWr = 1'b1; ctrl.fn = FN_MUL; end
        OP_AND:  begin ctrl.regWr = 1'b1; ctrl.fn = FN_AND; end
        OP_OR:   begin ctrl.regWr = 1'b1; ctrl.fn = FN_OR;  end
        OP_XOR:  begin ctrl.regWr = 1'b1; ctrl.fn = FN_XOR; end
        OP_NOT:  begin ctrl.regWr = 1'b1; ctrl.fn = FN_NOT; end
        OP_INC:  begin ctrl.regWr = 1'b1; ctrl.toOper = 1'b1; ctrl.fn = FN_INC; end
        OP_DEC:  begin ctrl.regWr = 1'b1; ctrl.toOper = 1'b1; ctrl.fn = FN_DEC; end
        OP_NEG:  begin ctrl.regWr = 1'b1; ctrl.toOper = 1'b1; ctrl.fn = FN_NEG; end
        OP_SHL:  begin ctrl.regWr = 1'b1; ctrl.toOper = 1'b1; ctrl.fn = FN_SHL; end
        OP_SHR:  begin ctrl.regWr = 1'b1; ctrl.toOper = 1'b1; ctrl.fn = FN_SHR; end
        OP_NEGB: begin
          ctrl.regWr = 1'b1; ctrl.toOper = 1'b1; ctrl.byteWr = 1'b1; ctrl.fn = FN_NEGB;
        end
        OP_LDB:  begin
          ctrl.regWr = 1'b1; ctrl.toOper = 1'b1; ctrl.byteWr = 1'b1; ctrl.fn = FN_LDB;
        end
        OP_DIV:  begin
          ctrl.regWr = 1'b1; ctrl.remWr = 1'b1; ctrl.zeroChk = 1'b1; ctrl.fn = FN_DIV;
        end
        OP_JNE:  begin ctrl.isBranch = 1'b1; ctrl.cmp = CMP_NE; end
        OP_JEQ:  begin ctrl.isBranch = 1'b1; ctrl.cmp = CMP_EQ; end
        OP_JGT:  begin ctrl.isBranch = 1'b1; ctrl.cmp = CMP_GT; end
        OP_JLT:  begin ctrl.isBranch = 1'b1; ctrl.cmp = CMP_LT; end
        OP_JGE:  begin ctrl.isBranch = 1'b1; ctrl.cmp = CMP_GE; end
        OP_JLE:  begin ctrl.isBranch = 1'b1; ctrl.cmp = CMP_LE; end
        OP_JMP:  begin ctrl.isBranch = 1'b1; ctrl.cmp = CMP_ALWAYS; end
        default: ctrl = ctrl; // NOP and undefined codes: no strobes (R9)
      endcase
    end
  end

endmodule

// File: rtl/accUnitDatapath.sv
module accUnitDatapath
  import accUnitPkg::*;
#(
  parameter int DataW = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic             useImm,
  input  logic [DataW-1:0] operandA,
  input  logic [DataW-1:0] operandB,
  input  logic [DataW-1:0] immValue,
  input  logic [DataW-1:0] accIn,
  input  logic [DataW-1:0] jumpTarget,
  output logic             wrEn,
  output logic             wrDest,
  output logic             wrByte,
  output logic [DataW-1:0] resultValue,
  output logic             remWrEn,
  output logic [DataW-1:0] remValue,
  output logic             branchTaken,
  output logic [DataW-1:0] branchTarget,
  output logic             divZeroErr
);

  localparam int ByteW = DataW / 2;
  localparam int ShW   = $clog2(DataW);
  localparam logic [DataW-1:0] ShLimit = DataW'(DataW);

  logic [DataW-1:0] src2;
  logic [ShW-1:0]   shAmt;
  logic             shSat;
  logic [DataW-1:0] shlVal, shrVal;
  logic [DataW-1:0] lowSext;
  logic [ByteW-1:0] negLow;
  logic             divZero;
  logic signed [DataW-1:0] sDividend, sDivisor, sQuot, sRem;
  logic [DataW-1:0] quotVal, remVal;
  logic signed [DataW-1:0] sCmp, sAcc;
  logic             cmpEq, cmpGt, cmpHit;
  logic [DataW-1:0] aluRes;

  // Second source feeds binary ops, shift amount, divisor and compare.
  assign src2 = useImm ? immValue : operandB;

  // Shifter with saturation for amounts at or beyond the word width.
  assign shAmt  = src2[ShW-1:0];
  assign shSat  = (src2 >= ShLimit);
  assign shlVal = shSat ? '0 : (operandA << shAmt);
  assign shrVal = shSat ? {DataW{operandA[DataW-1]}}
                        : DataW'($signed(operandA) >>> shAmt);

  // Byte negate on the sign-extended low byte.
  assign lowSext = {{(DataW-ByteW){operandA[ByteW-1]}}, operandA[ByteW-1:0]};
  assign negLow  = ByteW'(-lowSext);

  // Signed divider, truncating toward zero; zero divisor is defined.
  assign sDividend = $signed(operandA);
  assign sDivisor  = $signed(src2);
  assign divZero   = (src2 == '0);

  always_comb begin
    sQuot = '0;
    sRem  = '0;
    if (!divZero) begin
      sQuot = sDividend / sDivisor;
      sRem  = sDividend % sDivisor;
    end
  end

  assign quotVal = divZero ? '1 : DataW'(sQuot);
  assign remVal  = divZero ? operandA : DataW'(sRem);

  // Signed compare of the second source against the accumulator.
  assign sCmp  = $signed(src2);
  assign sAcc  = $signed(accIn);
  assign cmpEq = (sCmp == sAcc);
  assign cmpGt = (sCmp > sAcc);

  always_comb begin
    case (ctrl.cmp)
      CMP_NE:  cmpHit = !cmpEq;
      CMP_EQ:  cmpHit = cmpEq;
      CMP_GT:  cmpHit = cmpGt;
      CMP_LT:  cmpHit = !cmpGt && !cmpEq;
      CMP_GE:  cmpHit = cmpGt || cmpEq;
      CMP_LE:  cmpHit = !cmpGt;
      default: cmpHit = 1'b1;
    endcase
  end

  always_comb begin
    case (ctrl.fn)
      FN_ADD:  aluRes = operandA + src2;
      FN_SUB:  aluRes = operandA - src2;
      FN_MUL:  aluRes = DataW'(operandA * src2);
      FN_AND:  aluRes = operandA & src2;
      FN_OR:   aluRes = operandA | src2;
      FN_XOR:  aluRes = operandA ^ src2;
      FN_NOT:  aluRes = ~operandA;
      FN_INC:  aluRes = operandA + DataW'(1);
      FN_DEC:  aluRes = operandA - DataW'(1);
      FN_NEG:  aluRes = DataW'(-operandA);
      FN_NEGB: aluRes = {{(DataW-ByteW){1'b0}}, negLow};
      FN_SHL:  aluRes = shlVal;
      FN_SHR:  aluRes = shrVal;
      FN_DIV:  aluRes = quotVal;
      FN_LDB:  aluRes = {{(DataW-ByteW){1'b0}}, src2[ByteW-1:0]};
      default: aluRes = '0;
    endcase
  end

  // Single output register stage; strobes follow the gated control.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn         <= 1'b0;
      wrDest       <= 1'b0;
      wrByte       <= 1'b0;
      resultValue  <= '0;
      remWrEn      <= 1'b0;
      remValue     <= '0;
      branchTaken  <= 1'b0;
      branchTarget <= '0;
      divZeroErr   <= 1'b0;
    end else begin
      wrEn        <= ctrl.regWr;
      wrDest      <= ctrl.toOper;
      wrByte      <= ctrl.byteWr;
      remWrEn     <= ctrl.remWr;
      branchTaken <= ctrl.isBranch && cmpHit;
      divZeroErr  <= ctrl.zeroChk && divZero;
      if (ctrl.regWr)    resultValue  <= aluRes;
      if (ctrl.remWr)    remValue     <= remVal;
      if (ctrl.isBranch) branchTarget <= jumpTarget;
    end
  end

endmodule

// File: rtl/accBranchUnit.sv
module accBranchUnit
  import accUnitPkg::*;
#(
  parameter int DataW = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OP_W-1:0]  opCode,
  input  logic             useImm,
  input  logic [DataW-1:0] operandA,
  input  logic [DataW-1:0] operandB,
  input  logic [DataW-1:0] immValue,
  input  logic [DataW-1:0] accIn,
  input  logic [DataW-1:0] jumpTarget,
  output logic             wrEn,
  output logic             wrDest,
  output logic             wrByte,
  output logic [DataW-1:0] resultValue,
  output logic             remWrEn,
  output logic [DataW-1:0] remValue,
  output logic             branchTaken,
  output logic [DataW-1:0] branchTarget,
  output logic             divZeroErr
);

  ctrl_t ctrl;

  accUnitCtrl i_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  accUnitDatapath #(.DataW(DataW)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .useImm       (useImm),
    .operandA     (operandA),
    .operandB     (operandB),
    .immValue     (immValue),
    .accIn        (accIn),
    .jumpTarget   (jumpTarget),
    .wrEn         (wrEn),
    .wrDest       (wrDest),
    .wrByte       (wrByte),
    .resultValue  (resultValue),
    .remWrEn      (remWrEn),
    .remValue     (remValue),
    .branchTaken  (branchTaken),
    .branchTarget (branchTarget),
    .divZeroErr   (divZeroErr)
  );

endmodule

// File: rtl/accBranchChecker.sv
module accBranchChecker #(
  parameter int DataW = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [DataW-1:0] jumpTarget,
  input logic             wrEn,
  input logic             wrDest,
  input logic             wrByte,
  input logic [DataW-1:0] resultValue,
  input logic             remWrEn,
  input logic             branchTaken,
  input logic [DataW-1:0] branchTarget,
  input logic             divZeroErr
);

  localparam int ByteW = DataW / 2;

  AST_REM_WITH_ACC: assert property (@(posedge clk) disable iff (!rstN)
    remWrEn |-> (wrEn && !wrDest)); // R4

  AST_DIVZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    divZeroErr |-> (remWrEn && wrEn && (resultValue == '1))); // R5

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrByte) |-> (wrDest && (resultValue[DataW-1:ByteW] == '0))); // R6

  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({branchTaken, wrEn})); // R8

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (branchTarget == $past(jumpTarget))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(opValid) |-> !(wrEn || wrByte || remWrEn || branchTaken || divZeroErr)); // R9

endmodule

bind accBranchUnit accBranchChecker #(.DataW(DataW)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opValid      (opValid),
  .jumpTarget   (jumpTarget),
  .wrEn         (wrEn),
  .wrDest       (wrDest),
  .wrByte       (wrByte),
  .resultValue  (resultValue),
  .remWrEn      (remWrEn),
  .branchTaken  (branchTaken),
  .branchTarget (branchTarget),
  .divZeroErr   (divZeroErr)
);

// File: tb/test_accBranchUnit.sv
module test_accBranchUnit;

  typedef struct packed {
    logic [4:0]  op;
    logic        useImm;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] imm;
    logic [15:0] acc;
    logic [15:0] tgt;
    logic        expWr;
    logic        expDest;
    logic        expByte;
    logic [15:0] expRes;
    logic        expRem;
    logic [15:0] expRemV;
    logic        expBr;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 47;

  localparam vec_t VECS [NV] = '{
    '{5'd1, 1'b0,16'h1234,16'h0101,16'hFFFF,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'h1335, 1'b0,16'h0000, 1'b0,1'b0, 4'd1}, // R1 add reg
    '{5'd2, 1'b1,16'h0005,16'h0003,16'h0007,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hFFFE, 1'b0,16'h0000, 1'b0,1'b0, 4'd1}, // R1 sub imm
    '{5'd4, 1'b0,16'hF0F0,16'h3C3C,16'h0000,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'h3030, 1'b0,16'h0000, 1'b0,1'b0, 4'd1}, // R1 and
    '{5'd5, 1'b1,16'h00F0,16'hFFFF,16'h0F00,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'h0FF0, 1'b0,16'h0000, 1'b0,1'b0, 4'd1}, // R1 or imm
    '{5'd6, 1'b0,16'hFFFF,16'h1234,16'h0000,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hEDCB, 1'b0,16'h0000, 1'b0,1'b0, 4'd1}, // R1 xor
    '{5'd7, 1'b0,16'h00FF,16'h1111,16'h0000,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hFF00, 1'b0,16'h0000, 1'b0,1'b0, 4'd1}, // R1 not
    '{5'd3, 1'b0,16'h0300,16'h0101,16'h0000,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'h0300, 1'b0,16'h0000, 1'b0,1'b0, 4'd2}, // R2 overflow
    '{5'd3, 1'b1,16'hFFFE,16'h0000,16'h0003,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hFFFA, 1'b0,16'h0000, 1'b0,1'b0, 4'd2}, // R2 signed
    '{5'd3, 1'b0,16'h00FF,16'h00FF,16'h0000,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hFE01, 1'b0,16'h0000, 1'b0,1'b0, 4'd2}, // R2
    '{5'd8, 1'b0,16'h7FFF,16'h0000,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'h8000, 1'b0,16'h0000, 1'b0,1'b0, 4'd3}, // R3 inc
    '{5'd9, 1'b0,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'hFFFF, 1'b0,16'h0000, 1'b0,1'b0, 4'd3}, // R3 dec
    '{5'd10,1'b0,16'h0005,16'h0000,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'hFFFB, 1'b0,16'h0000, 1'b0,1'b0, 4'd3}, // R3 neg
    '{5'd10,1'b0,16'h8000,16'h0000,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'h8000, 1'b0,16'h0000, 1'b0,1'b0, 4'd3}, // R3 neg min
    '{5'd11,1'b1,16'h0081,16'h0000,16'h0004,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'h0810, 1'b0,16'h0000, 1'b0,1'b0, 4'd7}, // R7 shl 4
    '{5'd11,1'b0,16'h0001,16'h0100,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd7}, // R7 shl 256
    '{5'd11,1'b1,16'hFFFF,16'h0000,16'h0010,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd7}, // R7 shl 16
    '{5'd11,1'b1,16'h0001,16'h0000,16'h000F,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'h8000, 1'b0,16'h0000, 1'b0,1'b0, 4'd7}, // R7 shl 15
    '{5'd12,1'b0,16'h8000,16'h0003,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'hF000, 1'b0,16'h0000, 1'b0,1'b0, 4'd7}, // R7 sar 3
    '{5'd12,1'b1,16'h8001,16'h0000,16'h0010,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'hFFFF, 1'b0,16'h0000, 1'b0,1'b0, 4'd7}, // R7 sar 16
    '{5'd12,1'b1,16'h7000,16'h0000,16'h0014,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd7}, // R7 sar 20
    '{5'd12,1'b1,16'h7FFE,16'h0000,16'h0001,16'h0000,16'h0000, 1'b1,1'b1,1'b0,16'h3FFF, 1'b0,16'h0000, 1'b0,1'b0, 4'd7}, // R7 sar 1
    '{5'd13,1'b0,16'hFFF9,16'h0002,16'h0000,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hFFFD, 1'b1,16'hFFFF, 1'b0,1'b0, 4'd4}, // R4 -7/2
    '{5'd13,1'b1,16'h0064,16'h0000,16'h0007,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'h000E, 1'b1,16'h0002, 1'b0,1'b0, 4'd4}, // R4 100/7
    '{5'd13,1'b0,16'hFF9C,16'h0007,16'h0000,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hFFF2, 1'b1,16'hFFFE, 1'b0,1'b0, 4'd4}, // R4 -100/7
    '{5'd13,1'b0,16'h0064,16'hFFF9,16'h0000,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hFFF2, 1'b1,16'h0002, 1'b0,1'b0, 4'd4}, // R4 100/-7
    '{5'd13,1'b0,16'h1234,16'h0000,16'h0009,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hFFFF, 1'b1,16'h1234, 1'b0,1'b1, 4'd5}, // R5 reg zero
    '{5'd13,1'b1,16'h8000,16'h0005,16'h0000,16'h0000,16'h0000, 1'b1,1'b0,1'b0,16'hFFFF, 1'b1,16'h8000, 1'b0,1'b1, 4'd5}, // R5 imm zero
    '{5'd14,1'b0,16'h12FE,16'h0000,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b1,16'h0002, 1'b0,16'h0000, 1'b0,1'b0, 4'd6}, // R6 negb -2
    '{5'd14,1'b0,16'hAB80,16'h0000,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b1,16'h0080, 1'b0,16'h0000, 1'b0,1'b0, 4'd6}, // R6 negb -128
    '{5'd14,1'b0,16'h0001,16'h0000,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b1,16'h00FF, 1'b0,16'h0000, 1'b0,1'b0, 4'd6}, // R6 negb 1
    '{5'd15,1'b1,16'hFFFF,16'h0000,16'h5A7F,16'h0000,16'h0000, 1'b1,1'b1,1'b1,16'h007F, 1'b0,16'h0000, 1'b0,1'b0, 4'd6}, // R6 ldb imm
    '{5'd15,1'b0,16'hFFFF,16'h80C3,16'h0000,16'h0000,16'h0000, 1'b1,1'b1,1'b1,16'h00C3, 1'b0,16'h0000, 1'b0,1'b0, 4'd6}, // R6 ldb reg
    '{5'd17,1'b1,16'h0000,16'h0000,16'h0010,16'h0010,16'hABCD, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0, 4'd8}, // R8 jeq hit
    '{5'd17,1'b1,16'h0000,16'h0000,16'h0011,16'h0010,16'hABCD, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd8}, // R8 jeq miss
    '{5'd16,1'b0,16'h0000,16'h0010,16'h0000,16'h0010,16'h1111, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd8}, // R8 jne miss
    '{5'd16,1'b0,16'h0000,16'hFFF0,16'h0010,16'h0010,16'h2222, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0, 4'd8}, // R8 jne hit
    '{5'd18,1'b1,16'h0000,16'h0000,16'hFFFF,16'h0010,16'h3333, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd8}, // R8 jgt -1
    '{5'd18,1'b1,16'h0000,16'h0000,16'h0020,16'h0010,16'h4444, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0, 4'd8}, // R8 jgt 32
    '{5'd19,1'b0,16'h0000,16'h8000,16'h0000,16'h7FFF,16'h5555, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0, 4'd8}, // R8 jlt signed
    '{5'd19,1'b0,16'h0000,16'h0010,16'h0000,16'h0010,16'h6666, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd8}, // R8 jlt equal
    '{5'd20,1'b0,16'h0000,16'h0010,16'h0000,16'h0010,16'h7777, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0, 4'd8}, // R8 jge equal
    '{5'd20,1'b0,16'h0000,16'h000F,16'h0000,16'h0010,16'h8888, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd8}, // R8 jge below
    '{5'd21,1'b0,16'h0000,16'h0011,16'h0000,16'h0010,16'h9999, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd8}, // R8 jle above
    '{5'd21,1'b0,16'h0000,16'hFFFF,16'h0000,16'h0010,16'hAAAA, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0, 4'd8}, // R8 jle -1
    '{5'd22,1'b0,16'h0000,16'h0000,16'h0000,16'h0010,16'hBEEF, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0, 4'd8}, // R8 jmp
    '{5'd0, 1'b0,16'h1234,16'h0000,16'h0000,16'h0000,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd9}, // R9 nop
    '{5'd31,1'b0,16'h1234,16'h0000,16'h0000,16'h0000,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0, 4'd9}  // R9 undefined
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic        useImm = 1'b0;
  logic [15:0] operandA = '0, operandB = '0, immValue = '0, accIn = '0, jumpTarget = '0;
  logic        wrEn, wrDest, wrByte, remWrEn, branchTaken, divZeroErr;
  logic [15:0] resultValue, remValue, branchTarget;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  accBranchUnit i_accBranchUnit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .useImm(useImm),
    .operandA(operandA), .operandB(operandB), .immValue(immValue), .accIn(accIn),
    .jumpTarget(jumpTarget), .wrEn(wrEn), .wrDest(wrDest), .wrByte(wrByte),
    .resultValue(resultValue), .remWrEn(remWrEn), .remValue(remValue),
    .branchTaken(branchTaken), .branchTarget(branchTarget), .divZeroErr(divZeroErr)
  );

  function automatic logic [4:0] strobes();
    return {wrEn, wrByte, remWrEn, branchTaken, divZeroErr};
  endfunction

  task automatic checkQuiet(input string tag, input string what);
    checks++;
    if (strobes() !== 5'b0 || resultValue !== 16'h0 && what == "reset") begin
      fails++;
      $display("FAIL %s %s: strobes=%b res=%h expected strobes=00000", tag, what,
               strobes(), resultValue);
    end
  endtask

  task automatic runVec(input int idx);
    vec_t v;
    bit ok;
    v = VECS[idx];
    @(negedge clk);
    opValid = 1'b1; opCode = v.op; useImm = v.useImm;
    operandA = v.a; operandB = v.b; immValue = v.imm; accIn = v.acc; jumpTarget = v.tgt;
    @(negedge clk);
    opValid = 1'b0;
    ok = (wrEn === v.expWr) && (remWrEn === v.expRem) && (branchTaken === v.expBr) &&
         (divZeroErr === v.expErr);
    if (v.expWr)  ok = ok && (wrDest === v.expDest) && (wrByte === v.expByte) &&
                       (resultValue === v.expRes);
    else          ok = ok && (wrByte === 1'b0);
    if (v.expRem) ok = ok && (remValue === v.expRemV);
    if (v.expBr)  ok = ok && (branchTarget === v.tgt);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d vec %0d: got wr=%b dst=%b byte=%b res=%h rem=%b/%h br=%b/%h err=%b expected wr=%b dst=%b byte=%b res=%h rem=%b/%h br=%b/%h err=%b",
               v.req, idx, wrEn, wrDest, wrByte, resultValue, remWrEn, remValue,
               branchTaken, branchTarget, divZeroErr, v.expWr, v.expDest, v.expByte,
               v.expRes, v.expRem, v.expRemV, v.expBr, v.tgt, v.expErr);
    end
    // R9: idle cycle after the operation must show no strobes.
    @(negedge clk);
    checkQuiet("R9", "idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs are zero while in reset
    checkQuiet("R9", "reset");
    rstN = 1'b1;
    @(negedge clk);
    checkQuiet("R9", "reset");

    for (int i = 0; i < NV; i++) runVec(i);

    // R3: back-to-back in-place write after an accumulator write (no idle gap)
    @(negedge clk);
    opValid = 1'b1; opCode = 5'd1; useImm = 1'b1; operandA = 16'h0001; immValue = 16'h0001;
    @(negedge clk);
    opCode = 5'd8; operandA = 16'h00FF;
    checks++;
    if (!(wrEn && !wrDest && resultValue == 16'h0002)) begin
      fails++;
      $display("FAIL R1 b2b first: wr=%b dst=%b res=%h expected wr=1 dst=0 res=0002",
               wrEn, wrDest, resultValue);
    end
    @(negedge clk);
    opValid = 1'b0;
    checks++;
    if (!(wrEn && wrDest && resultValue == 16'h0100)) begin
      fails++;
      $display("FAIL R3 b2b second: wr=%b dst=%b res=%h expected wr=1 dst=1 res=0100",
               wrEn, wrDest, resultValue);
    end

    // R9: reset in the middle of a divide by zero clears every output
    @(negedge clk);
    opValid = 1'b1; opCode = 5'd13; useImm = 1'b0; operandA = 16'h4321; operandB = 16'h0000;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkQuiet("R9", "reset");
    checks++;
    if (remValue !== 16'h0 || branchTarget !== 16'h0) begin
      fails++;
      $display("FAIL R9 reset data: rem=%h tgt=%h expected 0000 0000", remValue, branchTarget);
    end
    @(negedge clk);
    opValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkQuiet("R9", "idle");

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

endmodule